// File: doc/BRIEF.md
# Abortable Frame Readback Serializer

The block sends a fixed number of stored frames out on one serial line. A rising trigger edge starts a readback. Each frame then occupies a slot of `LOAD_WIN + FRAME_BITS` clocks. The slot opens with a load window of `LOAD_WIN` clocks. During that window the next frame is read from a synchronous frame memory and placed in an output shift register. The window ends with a start bit. The frame's bits then follow, most significant first. Frames go out in index order with no gap between them.

All sequencing runs on one readback clock. A select input chooses that clock from a configuration clock and a user clock. A busy output is high for the whole readback. A load-window flag lets a host see where the frame boundaries fall.

When abort mode is enabled, a falling trigger ends the readback. The control logic then spends `FRAME_CNT` clocks re-initialising, and it ignores the trigger during that time. With abort mode off, a falling trigger has no effect.

Top module: `frame_readback`

## Requirements
- R1: When `clk_sel_i` is 1, all sequencing follows `clk_usr_i`, and a readback completes with `clk_cfg_i` stopped. When `clk_sel_i` is 0, all sequencing follows `clk_cfg_i`.
- R2: While reset is asserted and afterwards while idle, the outputs are `busy_o`=0, `data_o`=1, `load_win_o`=0 and `mem_en_o`=0.
- R3: A rising `trig_i`, sampled at a clock edge while the block is idle, makes `busy_o` 1 from the next cycle. That first cycle is cycle 0 of frame 0's load window.
- R4: Each frame slot works as follows. `load_win_o` is 1 for the first `LOAD_WIN` cycles. `data_o` is 1 for the first `LOAD_WIN-1` of those cycles and 0 (the start bit) in the last one. The `FRAME_BITS` data bits of the frame follow, most significant bit first.
- R5: `mem_en_o` is 1 for exactly the first cycle of each load window, with `mem_addr_o` equal to the frame index. The word returned on `mem_data_i` in the following cycle is the one that is serialised.
- R6: `busy_o` stays 1 until the last data bit of the last frame has gone out. It is 0 in the cycle after that bit.
- R7: Frames 0 to `FRAME_CNT-1` are sent in ascending order, with no idle cycles between slots.
- R8: With `abort_en_i`=1, a falling `trig_i` seen at an edge during a readback makes `busy_o` 0 and `data_o` 1 from the next cycle.
- R9: After an abort, the block ignores trigger edges for `FRAME_CNT` clocks. After that, a new rising edge starts a readback.
- R10: With `abort_en_i`=0, a falling `trig_i` during a readback has no effect, and the stream runs to its end.
- R11: A rising `trig_i` during a readback does not restart or disturb the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg_i | input | 1 | Configuration clock (default readback clock) |
| clk_usr_i | input | 1 | User-supplied readback clock |
| clk_sel_i | input | 1 | 1 selects `clk_usr_i`, 0 selects `clk_cfg_i` |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Readback trigger; its rising edge starts a readback, and its falling edge aborts one when abort mode is on |
| abort_en_i | input | 1 | Enables abort on a falling trigger |
| mem_en_o | output | 1 | Frame memory read enable |
| mem_addr_o | output | IDX_W | Frame memory read address (frame index) |
| mem_data_i | input | FRAME_BITS | Frame memory read data, valid one cycle after `mem_en_o` |
| data_o | output | 1 | Serial readback stream |
| busy_o | output | 1 | Readback in progress |
| load_win_o | output | 1 | High during each frame's load window |

## Verification
The bench builds the block with `FRAME_BITS`=8 and `FRAME_CNT`=3, keeping the default six-cycle load window. A whole readback then takes 42 clocks, so complete runs, mid-stream trigger toggles and aborts fit into a few hundred cycles. The three-cycle resynchronisation period is short enough that the bench can raise the trigger inside it and then restart right after it. With three distinct frame words, a misordered address or a misaligned load shows up in the stream bits.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    RB_IDLE   = 2'd0,
    RB_RUN    = 2'd1,
    RB_RESYNC = 2'd2
  } rb_state_e;
endpackage

// File: rtl/rb_clk_sel.sv
module rb_clk_sel (
  input  logic clk_cfg_i,
  input  logic clk_usr_i,
  input  logic sel_i,
  output logic clk_o
);
  // select is changed only while both clocks are low
  assign clk_o = sel_i ? clk_usr_i : clk_cfg_i;
endmodule

// File: rtl/rb_seq.sv
module rb_seq
  import rb_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int FRAME_CNT  = 4,
  parameter int LOAD_WIN   = 6,
  parameter int POS_W      = 5,
  parameter int IDX_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             abort_en_i,
  output rb_state_e        state_o,
  output logic [POS_W-1:0] pos_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int SLOT  = LOAD_WIN + FRAME_BITS;
  localparam int CNT_W = $clog2(FRAME_CNT + 1);

  rb_state_e        state_q;
  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             trig_q;
  logic             rise, fall;

  assign rise = trig_i & ~trig_q;
  assign fall = ~trig_i & trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RB_IDLE;
      pos_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= trig_i;
      unique case (state_q)
        RB_IDLE: if (rise) begin
          state_q <= RB_RUN;
          pos_q   <= '0;
          idx_q   <= '0;
        end
        RB_RUN: begin
          if (abort_en_i && fall) begin
            state_q <= RB_RESYNC;
            cnt_q   <= '0;
          end else if (pos_q == POS_W'(SLOT - 1)) begin
            pos_q <= '0;
            if (idx_q == IDX_W'(FRAME_CNT - 1)) state_q <= RB_IDLE;
            else idx_q <= idx_q + 1'b1;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        RB_RESYNC: begin
          // one clock per frame before the control logic is ready again
          if (cnt_q == CNT_W'(FRAME_CNT - 1)) state_q <= RB_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= RB_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign pos_o   = pos_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/rb_shift.sv
module rb_shift #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic [FRAME_BITS-1:0] data_i,
  output logic                  bit_o
);
  logic [FRAME_BITS-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= data_i;
    else if (shift_i) sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b0};
  end

  assign bit_o = sreg_q[FRAME_BITS-1];
endmodule

// File: rtl/frame_readback.sv
module frame_readback
  import rb_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int FRAME_CNT  = 4,
  parameter int LOAD_WIN   = 6,
  localparam int SLOT      = LOAD_WIN + FRAME_BITS,
  localparam int POS_W     = $clog2(SLOT),
  localparam int IDX_W     = (FRAME_CNT > 1) ? $clog2(FRAME_CNT) : 1
) (
  input  logic                  clk_cfg_i,
  input  logic                  clk_usr_i,
  input  logic                  clk_sel_i,
  input  logic                  rst_ni,
  input  logic                  trig_i,
  input  logic                  abort_en_i,
  output logic                  mem_en_o,
  output logic [IDX_W-1:0]      mem_addr_o,
  input  logic [FRAME_BITS-1:0] mem_data_i,
  output logic                  data_o,
  output logic                  busy_o,
  output logic                  load_win_o
);
  logic             rb_clk;
  rb_state_e        state;
  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] idx;
  logic             sbit;
  logic             busy, in_win;

  rb_clk_sel i_clk_sel (
    .clk_cfg_i (clk_cfg_i),
    .clk_usr_i (clk_usr_i),
    .sel_i     (clk_sel_i),
    .clk_o     (rb_clk)
  );

  rb_seq #(
    .FRAME_BITS (FRAME_BITS),
    .FRAME_CNT  (FRAME_CNT),
    .LOAD_WIN   (LOAD_WIN),
    .POS_W      (POS_W),
    .IDX_W      (IDX_W)
  ) i_seq (
    .clk_i      (rb_clk),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .abort_en_i (abort_en_i),
    .state_o    (state),
    .pos_o      (pos),
    .idx_o      (idx)
  );

  assign busy   = (state == RB_RUN);
  assign in_win = busy && (pos < POS_W'(LOAD_WIN));

  // read issued at window cycle 0, word captured at the end of cycle 1
  rb_shift #(.FRAME_BITS(FRAME_BITS)) i_shift (
    .clk_i   (rb_clk),
    .rst_ni  (rst_ni),
    .load_i  (busy && pos == POS_W'(1)),
    .shift_i (busy && !in_win),
    .data_i  (mem_data_i),
    .bit_o   (sbit)
  );

  always_comb begin
    if (!busy)                            data_o = 1'b1;
    else if (pos < POS_W'(LOAD_WIN - 1))  data_o = 1'b1;
    else if (pos == POS_W'(LOAD_WIN - 1)) data_o = 1'b0;
    else                                  data_o = sbit;
  end

  assign busy_o     = busy;
  assign load_win_o = in_win;
  assign mem_en_o   = busy && (pos == '0);
  assign mem_addr_o = idx;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic             abort_en_i,
  input logic             mem_en_i,
  input logic [IDX_W-1:0] mem_addr_i,
  input logic             data_i,
  input logic             busy_i,
  input logic             load_win_i
);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (data_i && !load_win_i && !mem_en_i));

  p_start_frame0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (mem_en_i && load_win_i && mem_addr_i == '0));

  p_start_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $fell(load_win_i)) |-> !$past(data_i));

  p_read_in_win_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_i |-> (load_win_i && busy_i));

  p_abort_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && abort_en_i && $past(trig_i) && !trig_i) |=> !busy_i);
endmodule

bind frame_readback rb_checker #(.IDX_W(IDX_W)) i_rb_checker (
  .clk_i      (rb_clk),
  .rst_ni     (rst_ni),
  .trig_i     (trig_i),
  .abort_en_i (abort_en_i),
  .mem_en_i   (mem_en_o),
  .mem_addr_i (mem_addr_o),
  .data_i     (data_o),
  .busy_i     (busy_o),
  .load_win_i (load_win_o)
);

// File: tb/test_frame_readback.sv
`timescale 1ns/1ps
module test_frame_readback;
  localparam int FB   = 8;
  localparam int FC   = 3;
  localparam int LW   = 6;
  localparam int SLOT = LW + FB;
  localparam int AW   = 2;

  logic cfg_clk = 0, usr_clk = 0, cfg_run = 1, usr_run = 0;
  logic sel = 0, rst_n = 0, trig = 0, abort_en = 0;
  logic bclk;
  logic mem_en, data, busy, win;
  logic [AW-1:0] mem_addr;
  logic [FB-1:0] mem_q = '0;
  logic [FB-1:0] fmem [FC];

  int tests = 0, fails = 0;
  bit done = 0;

  // 125 MHz, both clocks in phase while running
  initial forever begin
    #4;
    if (cfg_run) cfg_clk = ~cfg_clk;
    if (usr_run) usr_clk = ~usr_clk;
  end
  assign bclk = sel ? usr_clk : cfg_clk;

  initial for (int i = 0; i < FC; i++) fmem[i] = FB'(8'hA5 ^ (i * 8'h3B));

  always @(posedge bclk) if (mem_en) mem_q <= fmem[mem_addr];

  frame_readback #(.FRAME_BITS(FB), .FRAME_CNT(FC), .LOAD_WIN(LW)) i_frame_readback (
    .clk_cfg_i (cfg_clk), .clk_usr_i (usr_clk), .clk_sel_i (sel), .rst_ni (rst_n),
    .trig_i (trig), .abort_en_i (abort_en), .mem_en_o (mem_en), .mem_addr_o (mem_addr),
    .mem_data_i (mem_q), .data_o (data), .busy_o (busy), .load_win_o (win)
  );

  // behavioural reference: 0 idle, 1 running, 2 recovering
  int m_state = 0, m_pos = 0, m_idx = 0, m_cnt = 0;
  bit m_tq = 0;
  always @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_pos = 0; m_idx = 0; m_cnt = 0; m_tq = 0;
    end else begin
      bit rise, fall;
      rise = trig && !m_tq;
      fall = !trig && m_tq;
      if (m_state == 0) begin
        if (rise) begin m_state = 1; m_pos = 0; m_idx = 0; end
      end else if (m_state == 1) begin
        if (abort_en && fall) begin m_state = 2; m_cnt = 0; end
        else if (m_pos == SLOT - 1) begin
          m_pos = 0;
          if (m_idx == FC - 1) m_state = 0; else m_idx++;
        end else m_pos++;
      end else begin
        if (m_cnt == FC - 1) m_state = 0; else m_cnt++;
      end
      m_tq = trig;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    int e_busy, e_win, e_data, e_men;
    e_busy = (m_state == 1);
    e_win  = e_busy && m_pos < LW;
    e_men  = e_busy && m_pos == 0;
    if (!e_busy) e_data = 1;
    else if (m_pos < LW - 1) e_data = 1;
    else if (m_pos == LW - 1) e_data = 0;
    else e_data = fmem[m_idx][FB - 1 - (m_pos - LW)];
    chk("R6", "busy_o", busy, e_busy);
    chk("R4", "load_win_o", win, e_win);
    chk("R4", "data_o", data, e_data);
    chk("R5", "mem_en_o", mem_en, e_men);
    if (e_men) chk("R7", "mem_addr_o", mem_addr, m_idx);
  endtask

  task automatic step();
    @(negedge bclk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    run(3);
    chk("R2", "busy_o in reset", busy, 0);
    chk("R2", "data_o in reset", data, 1);
    rst_n = 1;
    run(2);
    chk("R2", "mem_en_o idle", mem_en, 0);

    // full readback on configuration clock
    trig = 1;
    step();
    chk("R3", "busy_o after rise", busy, 1);
    run(SLOT * FC + 3);
    chk("R6", "busy_o after end", busy, 0);

    // abort disabled: trigger toggles have no effect
    trig = 0; step(); trig = 1; step();
    run(10);
    trig = 0; step();
    chk("R10", "busy_o after fall", busy, 1);
    trig = 1; step();
    chk("R11", "busy_o after re-rise", busy, 1);
    run(SLOT * FC);
    chk("R10", "busy_o at end", busy, 0);

    // abort enabled
    abort_en = 1;
    trig = 0; step(); trig = 1; step();
    chk("R3", "busy_o after rise", busy, 1);
    run(20);
    trig = 0; step();
    chk("R8", "busy_o after abort", busy, 0);
    chk("R8", "data_o after abort", data, 1);
    trig = 1; step();
    chk("R9", "busy_o rise in recovery", busy, 0);
    run(5);
    chk("R9", "busy_o no late start", busy, 0);
    trig = 0; step(); trig = 1; step();
    chk("R9", "busy_o restart", busy, 1);
    run(SLOT * FC + 3);

    // switch to user clock with both clocks low, then stop the configuration clock
    sel = 1; usr_run = 1; cfg_run = 0;
    abort_en = 0;
    trig = 0; step(); trig = 1; step();
    chk("R1", "busy_o on user clock", busy, 1);
    run(SLOT * FC + 3);
    chk("R1", "busy_o done on user clock", busy, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule